// File: doc/BRIEF.md
# SD Command Token Framer

This block assembles the 48-bit command token that a host sends on the command line of an SD or MMC card. A single-cycle start strobe captures a 6-bit command index and a 32-bit argument. The block then runs a serial CRC7 over the first forty token bits, one bit per clock. When the checksum is complete it publishes the finished token in two forms. The first is three 16-bit words laid out for a register file. The second is a one-bit serial stream, sent most significant bit first.

A host controller uses the three words when its software path writes the token into command registers. It uses the serial output when the token drives the card's command pin directly. A one-cycle completion pulse marks the moment the words become valid and the serial stream begins. A start strobe that arrives while a token is in progress is dropped.

Top module: `sdcmd_frame_builder`

## Requirements
- R1: After reset, busy_o and done_o are 0, ser_o is 1, and all three word outputs are 0.
- R2: The token's first byte is 0x40 ORed with the 6-bit command index: bit 47 is 0 (start), bit 46 is 1 (host direction), and bits 45..40 hold the index. This byte appears in word_hi_o[15:8].
- R3: Token bits 39..8 carry the argument, most significant byte first. word_hi_o[7:0] is arg[31:24], word_mid_o is arg[23:8], and word_lo_o[15:8] is arg[7:0].
- R4: The CRC7 uses polynomial x^7+x^3+1 over token bits 47..8, taken MSB first. Its register starts at zero for every token. On each bit the register shifts left, and 0x09 is XORed in when the incoming bit differs from the register's top bit. word_lo_o[7:1] holds the CRC and word_lo_o[0] is the end bit, always 1. Two examples: index 0 with argument 0 gives word_lo_o = 0x0095, and index 8 with argument 0x000001AA gives 0xAA87.
- R5: A start accepted on clock edge E0 makes done_o high for exactly one cycle, following edge E40. busy_o is high from E0 until the serial stream ends.
- R6: In the cycle done_o is high, ser_o shows token bit 47. Each following edge moves it one bit lower, through bit 0, so the stream lasts 48 cycles. After that, busy_o falls and ser_o returns to 1.
- R7: A start strobe while busy_o is high is ignored. Neither the token being built nor the serial stream changes.
- R8: The word outputs change only in the cycle done_o rises. Between tokens they hold the last token, whatever the index and argument inputs do.
- R9: ser_o is 1 whenever busy_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| cmd_idx_i | input | 6 | Command index |
| cmd_arg_i | input | 32 | Command argument |
| busy_o | output | 1 | High while a token is computed or sent |
| done_o | output | 1 | One-cycle pulse when the token is ready |
| word_lo_o | output | 16 | Token bits 15..0 (last argument byte, CRC, end bit) |
| word_mid_o | output | 16 | Token bits 31..16 (middle argument bytes) |
| word_hi_o | output | 16 | Token bits 47..32 (header byte, first argument byte) |
| ser_o | output | 1 | Serial token, MSB first, idles high |

## Verification
Some properties are checked on every cycle: the idle-high line, the single-cycle completion pulse landing forty edges after an accepted start, the start, direction and end bits present at completion, and word outputs that stay frozen outside the completion cycle. The checksum itself, the placement of the argument bytes, the full 48-bit serial order and the immunity to strobes arriving mid-token can only be shown by the bench. The bench compares each token against a reference built from the command index and argument. Its cases are randomized indices and arguments, the two known checksum values, and deliberately injected stray strobes.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    // Controller phases
    typedef enum logic [1:0] {
        FB_IDLE = 2'd0,
        FB_CRC  = 2'd1,
        FB_SEND = 2'd2
    } fb_state_e;

    // Feedback taps for x^7 + x^3 + 1 (the x^7 term is implicit)
    localparam logic [6:0] SDCMD_CRC7_TAPS = 7'h09;

    // Token prefix: start bit 0, direction bit 1
    localparam logic [1:0] SDCMD_PREFIX = 2'b01;

endpackage

// File: rtl/sdcmd_crc7_engine.sv
module sdcmd_crc7_engine #(
    parameter int               CRC_W = 7,
    parameter logic [CRC_W-1:0] TAPS  = sdcmd_pkg::SDCMD_CRC7_TAPS
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             din_i,
    output logic [CRC_W-1:0] crc_next_o
);

    logic [CRC_W-1:0] crc_d, crc_q;
    logic [CRC_W-1:0] step;
    logic             fb;

    always_comb begin
        fb    = din_i ^ crc_q[CRC_W-1];
        step  = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? TAPS : '0);
        crc_d = crc_q;
        if (clr_i) begin
            crc_d = '0;
        end else if (en_i) begin
            crc_d = step;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            crc_q <= '0;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign crc_next_o = step;

endmodule

// File: rtl/sdcmd_tx_shifter.sv
module sdcmd_tx_shifter #(
    parameter int FRAME_W = 48
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] data_i,
    output logic               ser_o,
    output logic               last_o
);

    localparam int CNT_W = $clog2(FRAME_W);

    typedef struct packed {
        logic               active;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
    } tx_t;

    tx_t tx_d, tx_q;
    logic at_end;

    always_comb begin
        at_end = (tx_q.cnt == CNT_W'(FRAME_W - 1));
        tx_d   = tx_q;
        if (load_i) begin
            tx_d.active = 1'b1;
            tx_d.cnt    = '0;
            tx_d.sh     = data_i;
        end else if (tx_q.active) begin
            tx_d.sh  = {tx_q.sh[FRAME_W-2:0], 1'b1};
            tx_d.cnt = tx_q.cnt + 1'b1;
            if (at_end) begin
                tx_d.active = 1'b0;
                tx_d.cnt    = '0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tx_q <= '{active: 1'b0, cnt: '0, sh: '1};
        end else begin
            tx_q <= tx_d;
        end
    end

    // Line rests high outside a token
    assign ser_o  = tx_q.active ? tx_q.sh[FRAME_W-1] : 1'b1;
    assign last_o = tx_q.active && at_end;

endmodule

// File: rtl/sdcmd_frame_ctrl.sv
module sdcmd_frame_ctrl
    import sdcmd_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int ARG_W = 32,
    parameter int CRC_W = 7,
    localparam int BODY_W  = 2 + IDX_W + ARG_W,
    localparam int FRAME_W = BODY_W + CRC_W + 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [ARG_W-1:0]   arg_i,
    input  logic [CRC_W-1:0]   crc_next_i,
    input  logic               tx_last_i,
    output logic               crc_clr_o,
    output logic               crc_en_o,
    output logic               crc_din_o,
    output logic               tx_load_o,
    output logic [FRAME_W-1:0] tx_data_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic               busy_o,
    output logic               done_o
);

    localparam int CNT_W = $clog2(BODY_W);

    typedef struct packed {
        fb_state_e          state;
        logic [CNT_W-1:0]   cnt;
        logic [BODY_W-1:0]  body;
        logic [FRAME_W-1:0] frame;
        logic               done;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic [BODY_W-1:0] body_rot;

    always_comb begin
        // Rotating (not shifting) restores the body after BODY_W steps
        body_rot  = {c_q.body[BODY_W-2:0], c_q.body[BODY_W-1]};
        tx_data_o = {body_rot, crc_next_i, 1'b1};
        c_d       = c_q;
        c_d.done  = 1'b0;
        crc_clr_o = 1'b0;
        crc_en_o  = 1'b0;
        tx_load_o = 1'b0;
        unique case (c_q.state)
            FB_IDLE: begin
                if (start_i) begin
                    c_d.body  = {SDCMD_PREFIX, idx_i, arg_i};
                    c_d.cnt   = '0;
                    c_d.state = FB_CRC;
                    crc_clr_o = 1'b1;
                end
            end
            FB_CRC: begin
                crc_en_o = 1'b1;
                c_d.body = body_rot;
                c_d.cnt  = c_q.cnt + 1'b1;
                if (c_q.cnt == CNT_W'(BODY_W - 1)) begin
                    c_d.state = FB_SEND;
                    c_d.cnt   = '0;
                    c_d.frame = tx_data_o;
                    c_d.done  = 1'b1;
                    tx_load_o = 1'b1;
                end
            end
            FB_SEND: begin
                if (tx_last_i) begin
                    c_d.state = FB_IDLE;
                end
            end
            default: c_d.state = FB_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            c_q <= '{state: FB_IDLE, cnt: '0, body: '0, frame: '0, done: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign crc_din_o = c_q.body[BODY_W-1];
    assign frame_o   = c_q.frame;
    assign busy_o    = (c_q.state != FB_IDLE);
    assign done_o    = c_q.done;

endmodule

// File: rtl/sdcmd_frame_builder.sv
module sdcmd_frame_builder #(
    parameter int               IDX_W  = 6,
    parameter int               ARG_W  = 32,
    parameter int               CRC_W  = 7,
    parameter logic [CRC_W-1:0] TAPS   = sdcmd_pkg::SDCMD_CRC7_TAPS,
    parameter int               WORD_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  cmd_idx_i,
    input  logic [ARG_W-1:0]  cmd_arg_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] word_lo_o,
    output logic [WORD_W-1:0] word_mid_o,
    output logic [WORD_W-1:0] word_hi_o,
    output logic              ser_o
);

    localparam int BODY_W  = 2 + IDX_W + ARG_W;
    localparam int FRAME_W = BODY_W + CRC_W + 1;
    localparam int NWORDS  = FRAME_W / WORD_W;

    logic [CRC_W-1:0]   crc_next;
    logic               crc_clr, crc_en, crc_din;
    logic               tx_load, tx_last;
    logic [FRAME_W-1:0] tx_data, frame;
    logic [WORD_W-1:0]  words [NWORDS];

    sdcmd_frame_ctrl #(
        .IDX_W (IDX_W),
        .ARG_W (ARG_W),
        .CRC_W (CRC_W)
    ) u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .idx_i      (cmd_idx_i),
        .arg_i      (cmd_arg_i),
        .crc_next_i (crc_next),
        .tx_last_i  (tx_last),
        .crc_clr_o  (crc_clr),
        .crc_en_o   (crc_en),
        .crc_din_o  (crc_din),
        .tx_load_o  (tx_load),
        .tx_data_o  (tx_data),
        .frame_o    (frame),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    sdcmd_crc7_engine #(
        .CRC_W (CRC_W),
        .TAPS  (TAPS)
    ) u_crc (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (crc_clr),
        .en_i       (crc_en),
        .din_i      (crc_din),
        .crc_next_o (crc_next)
    );

    sdcmd_tx_shifter #(
        .FRAME_W (FRAME_W)
    ) u_tx (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (tx_load),
        .data_i (tx_data),
        .ser_o  (ser_o),
        .last_o (tx_last)
    );

    // Register-order packing: word 0 carries the token's tail
    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        assign words[g] = frame[g*WORD_W +: WORD_W];
    end

    assign word_lo_o  = words[0];
    assign word_mid_o = words[1];
    assign word_hi_o  = words[NWORDS-1];

endmodule

// File: rtl/sdcmd_frame_checker.sv
module sdcmd_frame_checker #(
    parameter int BODY_W = 40,
    parameter int WORD_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              ser_o,
    input logic [WORD_W-1:0] word_lo_o,
    input logic [WORD_W-1:0] word_mid_o,
    input logic [WORD_W-1:0] word_hi_o
);

    localparam int LAT_W = $clog2(BODY_W + 2);

    // Edges since the last accepted start, saturating past the done point
    logic [LAT_W-1:0] lat_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lat_q <= '0;
        end else if (start_i && !busy_o) begin
            lat_q <= LAT_W'(1);
        end else if (lat_q != '0 && lat_q <= LAT_W'(BODY_W)) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    p_idle_line_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> ser_o);

    p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_done_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (lat_q == LAT_W'(BODY_W + 1)) && busy_o);

    p_header_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (word_hi_o[WORD_W-1 -: 2] == 2'b01) && !ser_o);

    p_second_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> ser_o);

    p_end_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> word_lo_o[0]);

    p_words_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable({word_hi_o, word_mid_o, word_lo_o}));

endmodule

bind sdcmd_frame_builder sdcmd_frame_checker #(
    .BODY_W (2 + IDX_W + ARG_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .ser_o      (ser_o),
    .word_lo_o  (word_lo_o),
    .word_mid_o (word_mid_o),
    .word_hi_o  (word_hi_o)
);

// File: tb/sim_sdcmd_frame_builder.sv
module sim_sdcmd_frame_builder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  idx_in = '0;
    logic [31:0] arg_in = '0;
    logic        busy, done, ser;
    logic [15:0] w_lo, w_mid, w_hi;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sdcmd_frame_builder u0 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .cmd_idx_i  (idx_in),
        .cmd_arg_i  (arg_in),
        .busy_o     (busy),
        .done_o     (done),
        .word_lo_o  (w_lo),
        .word_mid_o (w_mid),
        .word_hi_o  (w_hi),
        .ser_o      (ser)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference checksum straight from the requirement text
    function automatic logic [6:0] ref_crc7(input logic [39:0] body);
        logic [6:0] c;
        c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic t;
            t = body[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (t) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [47:0] ref_token(input logic [5:0] ix, input logic [31:0] ag);
        logic [39:0] b;
        b = {8'h40 | {2'b00, ix}, ag};
        return {b, ref_crc7(b), 1'b1};
    endfunction

    task automatic do_frame(input logic [5:0] ix, input logic [31:0] ag,
                            input bit inject, input logic [15:0] lo_known, input bit use_known);
        logic [47:0] exp;
        int early;
        int bad;
        exp = ref_token(ix, ag);
        @(negedge clk);
        start = 1'b1; idx_in = ix; arg_in = ag;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R5 busy after start", 64'(busy), 64'd1);
        early = 0;
        for (int k = 1; k < 40; k++) begin
            if (inject && k == 10) begin
                start = 1'b1; idx_in = ~ix; arg_in = ~ag;
            end
            if (inject && k == 11) start = 1'b0;
            @(negedge clk);
            if (done) early++;
        end
        @(negedge clk);
        check(done == 1'b1 && early == 0, "R5 done after 40 edges",
              64'({early[7:0], 7'd0, done}), 64'd1);
        check(w_hi[15:8] == (8'h40 | {2'b00, ix}), "R2 header byte", 64'(w_hi[15:8]),
              64'(8'h40 | {2'b00, ix}));
        check({w_hi[7:0], w_mid, w_lo[15:8]} == ag, "R3 argument bytes",
              64'({w_hi[7:0], w_mid, w_lo[15:8]}), 64'(ag));
        check(w_lo[7:0] == exp[7:0], "R4 crc and end bit", 64'(w_lo[7:0]), 64'(exp[7:0]));
        if (use_known)
            check(w_lo == lo_known, "R4 known crc value", 64'(w_lo), 64'(lo_known));
        if (inject)
            check({w_hi, w_mid, w_lo} == exp, "R7 stray start mid-crc ignored",
                  64'({w_hi, w_mid, w_lo}), 64'(exp));
        bad = 0;
        for (int b = 0; b < 48; b++) begin
            if (ser != exp[47-b]) bad++;
            if (inject && b == 20) begin
                start = 1'b1; idx_in = ~ix; arg_in = ~ag;
            end
            if (inject && b == 21) start = 1'b0;
            @(negedge clk);
        end
        check(bad == 0, inject ? "R7 serial stream with stray starts" : "R6 serial order",
              64'(bad), 64'd0);
        check(busy == 1'b0 && ser == 1'b1, "R6 stream end returns idle",
              64'({busy, ser}), 64'b01);
        check({w_hi, w_mid, w_lo} == exp, "R8 words held after stream",
              64'({w_hi, w_mid, w_lo}), 64'(exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [47:0] held;
        void'($urandom(32'h5D0C_A11E));
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && ser == 1 && {w_hi, w_mid, w_lo} == 48'd0,
              "R1 reset state", 64'({busy, done, ser, w_hi, w_mid, w_lo}), 64'(51'h1 << 48));
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && ser == 1, "R9 idle line high", 64'({busy, ser}), 64'b01);

        do_frame(6'd0, 32'h0000_0000, 1'b0, 16'h0095, 1'b1);
        do_frame(6'd8, 32'h0000_01AA, 1'b1, 16'hAA87, 1'b1);
        do_frame(6'h3F, 32'hFFFF_FFFF, 1'b0, 16'h0, 1'b0);
        do_frame(6'd17, 32'h8000_0001, 1'b1, 16'h0, 1'b0);

        // R8: inputs move without a start; words and line stay put
        held = {w_hi, w_mid, w_lo};
        for (int i = 0; i < 6; i++) begin
            idx_in = 6'($urandom);
            arg_in = $urandom;
            @(negedge clk);
        end
        check({w_hi, w_mid, w_lo} == held, "R8 words ignore input changes",
              64'({w_hi, w_mid, w_lo}), 64'(held));
        check(ser == 1'b1 && busy == 1'b0, "R9 line high while idle", 64'({busy, ser}), 64'b01);

        for (int n = 0; n < 16; n++) begin
            do_frame(6'($urandom), $urandom, bit'($urandom & 1), 16'h0, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule